// File: doc/BRIEF.md
# Processor Bus Cycle Monitor

This block sits passively beside a 32-bit processor local bus and never drives it. On every clock in which the address strobe is active it captures the three cycle-definition lines, the byte enables and the low address bits A4-A2, then reports what kind of bus cycle has begun. That includes the three named special cycles: shutdown, halt and stop-grant. It follows the cycle until a ready input ends it, counts the data transfers of a burst and pulses a done strobe at the end.

It also tracks the bus-lock line so that the start and the end of a locked sequence show up as single-clock pulses. It samples the multi-cycle lock line only in the clock where ready is returned, which tells the observer that more cycles of the same transaction follow.

Rule breaks set bits in a sticky error vector that only reset clears. The monitor is meant for debug observation points and for protocol checking inside a larger verification setup.

Top module: `bus_cycle_monitor`

## Requirements
- R1: On a clock with `addr_strobe_n` low, `cyc_type` takes, from the next clock on, the code {`cyc_is_mem`,`cyc_is_data`,`cyc_is_write`}. The encoding is 0 interrupt acknowledge, 1 special, 2 I/O read, 3 I/O write, 4 code read, 5 reserved, 6 memory read and 7 memory write.
- R2: For code 1, `cyc_type` is 8 (shutdown) when `byte_en_n`=1110 and `addr_sel`=000. It is 9 (halt) when `byte_en_n`=1011 and `addr_sel`=000, and 10 (stop-grant) when `byte_en_n`=1011 and `addr_sel`=100. Any other pattern with code 1 stays 1.
- R3: `cyc_type` is 15 after reset and changes only in the clock after a strobe.
- R4: A cycle is outstanding from its strobe until it completes. It completes on a clock with `ready_n` low, or with `burst_ready_n` and `burst_last_n` both low. `cyc_done` is high for exactly the clock after each completion.
- R5: `cyc_beats` is updated at each completion to the number of transfers in the cycle. Each `burst_ready_n` low with `burst_last_n` high counts one transfer and the final transfer counts one more. The value saturates at 2^BEAT_W-1 (7 by default) and holds until the next completion.
- R6: `lock_begin` pulses and `lock_active` rises the clock after a strobe with `bus_lock_n` low while no lock sequence is active. `lock_end` pulses and `lock_active` falls the clock after `bus_lock_n` is seen high during a lock sequence with no cycle outstanding.
- R7: `xact_more` takes the inverse of `multi_lock_n` only at a completion and holds at all other times.
- R8: `err_flags[0]` sets after a strobe carrying the reserved code 5.
- R9: `err_flags[1]` sets after a strobe while a cycle is outstanding; the new cycle replaces the old one.
- R10: `err_flags[2]` sets after a clock with `hold_grant` high and `bus_lock_n` low.
- R11: `err_flags[3]` sets after a burst transfer that does not end the cycle, within a locked read cycle (write line low).
- R12: `err_flags[4]` sets after a clock with `ready_n` or `burst_ready_n` low while no cycle is outstanding.
- R13: `err_flags[5]` sets after a clock with `bus_lock_n` high while a cycle that started locked is outstanding.
- R14: Every `err_flags` bit stays set until reset, and reset clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_strobe_n | input | 1 | Active-low address strobe, start of a cycle |
| cyc_is_mem | input | 1 | Definition line: 1 memory, 0 I/O |
| cyc_is_data | input | 1 | Definition line: 1 data, 0 control/code |
| cyc_is_write | input | 1 | Definition line: 1 write, 0 read |
| byte_en_n | input | 4 | Active-low byte enables, bit 3 highest |
| addr_sel | input | 3 | Address bits A4-A2 |
| ready_n | input | 1 | Active-low non-burst ready |
| burst_ready_n | input | 1 | Active-low burst ready |
| burst_last_n | input | 1 | Active-low last-transfer marker |
| bus_lock_n | input | 1 | Active-low bus lock |
| multi_lock_n | input | 1 | Active-low multi-cycle transaction lock |
| hold_grant | input | 1 | Bus hold acknowledge |
| cyc_type | output | 4 | Type of the latest cycle (R1, R2, R3) |
| cyc_done | output | 1 | Completion pulse |
| cyc_beats | output | BEAT_W | Transfers in the last completed cycle |
| xact_more | output | 1 | Multi-cycle lock sampled at the last completion |
| lock_active | output | 1 | Locked sequence in progress |
| lock_begin | output | 1 | Lock sequence start pulse |
| lock_end | output | 1 | Lock sequence end pulse |
| err_flags | output | 6 | Sticky protocol error bits (R8-R13) |

## Verification
The hardest situations to reach are the ones where two rules meet in the same clock. One is a lock line released while a locked cycle is still waiting for ready. Another is a burst continuation inside a locked read. A third is a new strobe arriving before the previous cycle has completed. The bench reaches each of them with directed sequences that hold ready back on purpose, raise the lock line early, or issue a second strobe in the following clock. A behavioural model runs beside the block and compares every output on every clock.

// File: rtl/bcm_pkg.sv
// Shared types for the bus cycle monitor.
// Assumes a 4-bit cycle type code and six sticky error sources.
package bcm_pkg;

    typedef enum logic [3:0] {
        CT_INTA      = 4'd0,
        CT_SPECIAL   = 4'd1,
        CT_IO_RD     = 4'd2,
        CT_IO_WR     = 4'd3,
        CT_CODE_RD   = 4'd4,
        CT_RSVD      = 4'd5,
        CT_MEM_RD    = 4'd6,
        CT_MEM_WR    = 4'd7,
        CT_SHUTDOWN  = 4'd8,
        CT_HALT      = 4'd9,
        CT_STOPGRANT = 4'd10,
        CT_NONE      = 4'd15
    } cyc_type_e;

    localparam int ERR_W          = 6;
    localparam int ERR_RSVD       = 0;
    localparam int ERR_OVERLAP    = 1;
    localparam int ERR_HOLD_LOCK  = 2;
    localparam int ERR_LOCK_BURST = 3;
    localparam int ERR_STRAY_RDY  = 4;
    localparam int ERR_EARLY_REL  = 5;

endpackage

// File: rtl/bcm_decode.sv
// Combinational cycle classifier.
// Maps the definition code plus byte-enable and address patterns to a type.
// Assumes inputs are only meaningful in a strobe clock; the caller latches.
module bcm_decode
    import bcm_pkg::*;
(
    input  logic [2:0] def_code,
    input  logic [3:0] byte_en_n,
    input  logic [2:0] addr_sel,
    output cyc_type_e  kind,
    output logic       is_reserved
);

    // Pick the base type, then refine special cycles by their patterns.
    always_comb begin
        kind = cyc_type_e'({1'b0, def_code});
        if (def_code == 3'b001) begin
            if (byte_en_n == 4'b1110 && addr_sel == 3'b000) begin
                kind = CT_SHUTDOWN;
            end else if (byte_en_n == 4'b1011 && addr_sel == 3'b000) begin
                kind = CT_HALT;
            end else if (byte_en_n == 4'b1011 && addr_sel == 3'b100) begin
                kind = CT_STOPGRANT;
            end
        end
    end

    assign is_reserved = (def_code == 3'b101);

endmodule

// File: rtl/bcm_cycle_track.sv
// Follows one outstanding bus cycle from strobe to completion.
// Counts burst transfers, emits the done pulse, samples the multi-cycle lock,
// and raises single-clock error events for the sticky register in the top.
// Assumes at most one cycle outstanding; a second strobe replaces the first.
module bcm_cycle_track
    import bcm_pkg::*;
#(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cyc_type_e         start_kind,
    input  logic              start_locked,
    input  logic              start_write,
    input  logic              ready_n,
    input  logic              burst_ready_n,
    input  logic              burst_last_n,
    input  logic              multi_lock_n,
    output logic              busy,
    output logic              cur_locked,
    output cyc_type_e         cur_kind,
    output logic              done,
    output logic [BEAT_W-1:0] beats,
    output logic              more,
    output logic              evt_overlap,
    output logic              evt_stray,
    output logic              evt_locked_burst
);

    localparam logic [BEAT_W-1:0] BEAT_MAX = '1;

    logic              cur_write;
    logic [BEAT_W-1:0] beat_cnt;
    logic              finish;
    logic              mid_beat;

    // Completion and intermediate burst transfer for the current clock.
    always_comb begin
        finish   = busy && (!ready_n || (!burst_ready_n && !burst_last_n));
        mid_beat = busy && ready_n && !burst_ready_n && burst_last_n;
    end

    // Error events seen this clock.
    always_comb begin
        evt_overlap      = start && busy;
        evt_stray        = !busy && (!ready_n || !burst_ready_n);
        evt_locked_burst = mid_beat && cur_locked && !cur_write;
    end

    // Outstanding flag: a strobe opens a cycle, a completion closes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
        end else if (finish) begin
            busy <= 1'b0;
        end
    end

    // Attributes captured in the strobe clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind   <= CT_NONE;
            cur_locked <= 1'b0;
            cur_write  <= 1'b0;
        end else if (start) begin
            cur_kind   <= start_kind;
            cur_locked <= start_locked;
            cur_write  <= start_write;
        end
    end

    // Saturating count of intermediate burst transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt <= '0;
        end else if (start) begin
            beat_cnt <= '0;
        end else if (mid_beat && beat_cnt != BEAT_MAX) begin
            beat_cnt <= beat_cnt + 1'b1;
        end
    end

    // Completion results: done pulse, transfer count, multi-cycle lock sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            beats <= '0;
            more  <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                beats <= (beat_cnt == BEAT_MAX) ? BEAT_MAX : beat_cnt + 1'b1;
                more  <= !multi_lock_n;
            end
        end
    end

endmodule

// File: rtl/bcm_lock_track.sv
// Tracks locked sequences and checks the lock timing rules.
// A sequence opens on a strobe with the lock line low and closes once the
// lock line is high with no cycle outstanding.
// Assumes busy and cur_locked come from the cycle tracker's registers.
module bcm_lock_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bus_lock_n,
    input  logic hold_grant,
    input  logic busy,
    input  logic cur_locked,
    output logic lock_active,
    output logic lock_begin,
    output logic lock_end,
    output logic evt_hold_in_lock,
    output logic evt_early_release
);

    // Rule checks: no hold grant under lock, no release inside a locked cycle.
    always_comb begin
        evt_hold_in_lock  = hold_grant && !bus_lock_n;
        evt_early_release = busy && cur_locked && bus_lock_n;
    end

    // Sequence state with single-clock begin and end pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_active <= 1'b0;
            lock_begin  <= 1'b0;
            lock_end    <= 1'b0;
        end else begin
            lock_begin <= 1'b0;
            lock_end   <= 1'b0;
            if (start && !bus_lock_n && !lock_active) begin
                lock_active <= 1'b1;
                lock_begin  <= 1'b1;
            end else if (lock_active && bus_lock_n && !busy) begin
                lock_active <= 1'b0;
                lock_end    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bus_cycle_monitor.sv
// Passive processor bus cycle monitor (top).
// Classifies each cycle at its strobe, follows it to completion, tracks lock
// sequences and collects protocol violations into sticky error bits.
// Assumes all inputs are synchronous to clk and never drives the bus.
module bus_cycle_monitor
    import bcm_pkg::*;
#(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_strobe_n,
    input  logic              cyc_is_mem,
    input  logic              cyc_is_data,
    input  logic              cyc_is_write,
    input  logic [3:0]        byte_en_n,
    input  logic [2:0]        addr_sel,
    input  logic              ready_n,
    input  logic              burst_ready_n,
    input  logic              burst_last_n,
    input  logic              bus_lock_n,
    input  logic              multi_lock_n,
    input  logic              hold_grant,
    output logic [3:0]        cyc_type,
    output logic              cyc_done,
    output logic [BEAT_W-1:0] cyc_beats,
    output logic              xact_more,
    output logic              lock_active,
    output logic              lock_begin,
    output logic              lock_end,
    output logic [ERR_W-1:0]  err_flags
);

    logic             start;
    cyc_type_e        new_kind;
    cyc_type_e        cur_kind;
    logic             is_reserved;
    logic             busy;
    logic             cur_locked;
    logic [ERR_W-1:0] err_evt;

    assign start = !addr_strobe_n;

    bcm_decode decode_i (
        .def_code    ({cyc_is_mem, cyc_is_data, cyc_is_write}),
        .byte_en_n   (byte_en_n),
        .addr_sel    (addr_sel),
        .kind        (new_kind),
        .is_reserved (is_reserved)
    );

    bcm_cycle_track #(.BEAT_W(BEAT_W)) track_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .start            (start),
        .start_kind       (new_kind),
        .start_locked     (!bus_lock_n),
        .start_write      (cyc_is_write),
        .ready_n          (ready_n),
        .burst_ready_n    (burst_ready_n),
        .burst_last_n     (burst_last_n),
        .multi_lock_n     (multi_lock_n),
        .busy             (busy),
        .cur_locked       (cur_locked),
        .cur_kind         (cur_kind),
        .done             (cyc_done),
        .beats            (cyc_beats),
        .more             (xact_more),
        .evt_overlap      (err_evt[ERR_OVERLAP]),
        .evt_stray        (err_evt[ERR_STRAY_RDY]),
        .evt_locked_burst (err_evt[ERR_LOCK_BURST])
    );

    bcm_lock_track lock_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .start             (start),
        .bus_lock_n        (bus_lock_n),
        .hold_grant        (hold_grant),
        .busy              (busy),
        .cur_locked        (cur_locked),
        .lock_active       (lock_active),
        .lock_begin        (lock_begin),
        .lock_end          (lock_end),
        .evt_hold_in_lock  (err_evt[ERR_HOLD_LOCK]),
        .evt_early_release (err_evt[ERR_EARLY_REL])
    );

    assign err_evt[ERR_RSVD] = start && is_reserved;
    assign cyc_type          = cur_kind;

    // One sticky bit per error source, cleared only by reset.
    for (genvar g = 0; g < ERR_W; g++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                err_flags[g] <= 1'b0;
            end else if (err_evt[g]) begin
                err_flags[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcm_checker.sv
// Protocol assertions for bus_cycle_monitor, attached with bind.
// Assumes a synchronous active-low reset held for at least two clocks.
module bcm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       addr_strobe_n,
    input logic       cyc_is_mem,
    input logic       cyc_is_data,
    input logic       cyc_is_write,
    input logic       ready_n,
    input logic       burst_ready_n,
    input logic       burst_last_n,
    input logic       bus_lock_n,
    input logic       hold_grant,
    input logic [3:0] cyc_type,
    input logic       cyc_done,
    input logic       xact_more,
    input logic       lock_active,
    input logic       lock_begin,
    input logic       lock_end,
    input logic [5:0] err_flags
);

    assert_type_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe_n |=> $stable(cyc_type));

    assert_done_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> $past(!ready_n || (!burst_ready_n && !burst_last_n)));

    assert_lock_begin_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_begin |-> (lock_active && $past(!addr_strobe_n && !bus_lock_n)));

    assert_lock_edges_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_begin && lock_end));

    assert_more_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_done |-> $stable(xact_more));

    assert_reserved_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_strobe_n && {cyc_is_mem, cyc_is_data, cyc_is_write} == 3'b101)
        |=> err_flags[0]);

    assert_hold_in_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_grant && !bus_lock_n) |=> err_flags[2]);

    assert_sticky_R14: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

endmodule

bind bus_cycle_monitor bcm_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_strobe_n (addr_strobe_n),
    .cyc_is_mem    (cyc_is_mem),
    .cyc_is_data   (cyc_is_data),
    .cyc_is_write  (cyc_is_write),
    .ready_n       (ready_n),
    .burst_ready_n (burst_ready_n),
    .burst_last_n  (burst_last_n),
    .bus_lock_n    (bus_lock_n),
    .hold_grant    (hold_grant),
    .cyc_type      (cyc_type),
    .cyc_done      (cyc_done),
    .xact_more     (xact_more),
    .lock_active   (lock_active),
    .lock_begin    (lock_begin),
    .lock_end      (lock_end),
    .err_flags     (err_flags)
);

// File: tb/bus_cycle_monitor_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the monitor every clock,
// plus directed checks at the moments the requirements call out.
module bus_cycle_monitor_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ads_s = 1'b1;
    logic [2:0] code_s = 3'b000;
    logic [3:0] be_s = 4'b1111;
    logic [2:0] sel_s = 3'b000;
    logic       rdy_s = 1'b1;
    logic       brdy_s = 1'b1;
    logic       last_s = 1'b1;
    logic       lock_s = 1'b1;
    logic       plock_s = 1'b1;
    logic       hold_s = 1'b0;

    logic [3:0] cyc_type;
    logic       cyc_done;
    logic [2:0] cyc_beats;
    logic       xact_more;
    logic       lock_active;
    logic       lock_begin;
    logic       lock_end;
    logic [5:0] err_flags;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    bus_cycle_monitor dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_strobe_n (ads_s),
        .cyc_is_mem    (code_s[2]),
        .cyc_is_data   (code_s[1]),
        .cyc_is_write  (code_s[0]),
        .byte_en_n     (be_s),
        .addr_sel      (sel_s),
        .ready_n       (rdy_s),
        .burst_ready_n (brdy_s),
        .burst_last_n  (last_s),
        .bus_lock_n    (lock_s),
        .multi_lock_n  (plock_s),
        .hold_grant    (hold_s),
        .cyc_type      (cyc_type),
        .cyc_done      (cyc_done),
        .cyc_beats     (cyc_beats),
        .xact_more     (xact_more),
        .lock_active   (lock_active),
        .lock_begin    (lock_begin),
        .lock_end      (lock_end),
        .err_flags     (err_flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected type from the requirement text (R1, R2).
    function automatic int want_type(input logic [2:0] c, input logic [3:0] be,
                                     input logic [2:0] a);
        if (c != 3'b001) return int'(c);
        if (be == 4'b1110 && a == 3'b000) return 8;
        if (be == 4'b1011 && a == 3'b000) return 9;
        if (be == 4'b1011 && a == 3'b100) return 10;
        return 1;
    endfunction

    // Reference model state.
    bit m_ready = 0;
    bit m_open, m_lk, m_wr, m_done, m_more, m_lact, m_lbeg, m_lend;
    bit fin, mid;
    int m_type, m_cnt, m_beats;
    bit [5:0] m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ready = 1; m_open = 0; m_lk = 0; m_wr = 0; m_done = 0; m_more = 0;
            m_lact = 0; m_lbeg = 0; m_lend = 0; m_type = 15; m_cnt = 0;
            m_beats = 0; m_err = '0;
        end else begin
            fin = m_open && (!rdy_s || (!brdy_s && !last_s));
            mid = m_open && rdy_s && !brdy_s && last_s;
            if (!ads_s && code_s == 3'b101) m_err[0] = 1;
            if (!ads_s && m_open) m_err[1] = 1;
            if (hold_s && !lock_s) m_err[2] = 1;
            if (mid && m_lk && !m_wr) m_err[3] = 1;
            if (!m_open && (!rdy_s || !brdy_s)) m_err[4] = 1;
            if (m_open && m_lk && lock_s) m_err[5] = 1;
            m_lbeg = 0; m_lend = 0;
            if (!ads_s && !lock_s && !m_lact) begin
                m_lact = 1; m_lbeg = 1;
            end else if (m_lact && lock_s && !m_open) begin
                m_lact = 0; m_lend = 1;
            end
            m_done = fin;
            if (fin) begin
                m_beats = (m_cnt >= 7) ? 7 : m_cnt + 1;
                m_more  = !plock_s;
                m_open  = 0;
            end
            if (mid && m_cnt < 7) m_cnt++;
            if (!ads_s) begin
                m_open = 1; m_type = want_type(code_s, be_s, sel_s);
                m_lk = !lock_s; m_wr = code_s[0]; m_cnt = 0;
            end
        end
    end

    // Clock-by-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (m_ready) begin
            chk("R1 cyc_type", int'(cyc_type), m_type);
            chk("R4 cyc_done", int'(cyc_done), int'(m_done));
            chk("R5 cyc_beats", int'(cyc_beats), m_beats);
            chk("R7 xact_more", int'(xact_more), int'(m_more));
            chk("R6 lock_active", int'(lock_active), int'(m_lact));
            chk("R6 lock_begin", int'(lock_begin), int'(m_lbeg));
            chk("R6 lock_end", int'(lock_end), int'(m_lend));
            chk("R8 err reserved", int'(err_flags[0]), int'(m_err[0]));
            chk("R9 err overlap", int'(err_flags[1]), int'(m_err[1]));
            chk("R10 err hold", int'(err_flags[2]), int'(m_err[2]));
            chk("R11 err locked burst", int'(err_flags[3]), int'(m_err[3]));
            chk("R12 err stray ready", int'(err_flags[4]), int'(m_err[4]));
            chk("R13 err early release", int'(err_flags[5]), int'(m_err[5]));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    // One cycle: strobe clock, then nbeats transfers; the last one ends it.
    task automatic run_cycle(input logic [2:0] c, input logic [3:0] be,
                             input logic [2:0] a, input logic lk,
                             input int nbeats, input logic plk);
        ads_s = 1'b0; code_s = c; be_s = be; sel_s = a; lock_s = lk;
        tick();
        ads_s = 1'b1;
        for (int i = 0; i < nbeats - 1; i++) begin
            brdy_s = 1'b0; last_s = 1'b1;
            tick();
        end
        if (nbeats > 1) begin
            brdy_s = 1'b0; last_s = 1'b0;
        end else begin
            rdy_s = 1'b0;
        end
        plock_s = plk;
        tick();
        rdy_s = 1'b1; brdy_s = 1'b1; last_s = 1'b1; plock_s = 1'b1;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5) tick();
        chk("R3 reset type", int'(cyc_type), 15);
        chk("R14 reset errors", int'(err_flags), 0);
        rst_n = 1'b1;
        tick();

        // Plain cycles, every non-reserved definition code (R1).
        for (int c = 0; c < 8; c++) begin
            if (c != 5) begin
                run_cycle(3'(c), 4'b0000, 3'b000, 1'b1, 1, 1'b1);
                chk("R1 plain type", int'(cyc_type), c);
                chk("R4 done after ready", int'(cyc_done), 1);
                tick();
            end
        end

        // Special cycles and their patterns (R2).
        run_cycle(3'b001, 4'b1110, 3'b000, 1'b1, 1, 1'b1);
        chk("R2 shutdown", int'(cyc_type), 8);
        run_cycle(3'b001, 4'b1011, 3'b000, 1'b1, 1, 1'b1);
        chk("R2 halt", int'(cyc_type), 9);
        run_cycle(3'b001, 4'b1011, 3'b100, 1'b1, 1, 1'b1);
        chk("R2 stop grant", int'(cyc_type), 10);
        run_cycle(3'b001, 4'b1011, 3'b010, 1'b1, 1, 1'b1);
        chk("R2 other special", int'(cyc_type), 1);
        tick();
        chk("R4 done single clock", int'(cyc_done), 0);

        // Four-transfer burst read, then a saturating long burst (R5).
        run_cycle(3'b110, 4'b0000, 3'b000, 1'b1, 4, 1'b1);
        chk("R5 four beats", int'(cyc_beats), 4);
        tick(); tick();
        chk("R5 beats held", int'(cyc_beats), 4);
        run_cycle(3'b100, 4'b0000, 3'b000, 1'b1, 9, 1'b1);
        chk("R5 saturated beats", int'(cyc_beats), 7);

        // Multi-cycle transaction: lock sampled only at ready (R7).
        run_cycle(3'b110, 4'b0000, 3'b000, 1'b1, 1, 1'b0);
        chk("R7 more after first", int'(xact_more), 1);
        plock_s = 1'b1;
        tick();
        chk("R7 held off ready", int'(xact_more), 1);
        run_cycle(3'b110, 4'b0000, 3'b100, 1'b1, 1, 1'b1);
        chk("R7 last of transaction", int'(xact_more), 0);

        // Locked read-modify-write pair (R6).
        run_cycle(3'b110, 4'b1100, 3'b000, 1'b0, 1, 1'b1);
        chk("R6 lock active", int'(lock_active), 1);
        tick();
        run_cycle(3'b111, 4'b1100, 3'b000, 1'b0, 1, 1'b1);
        chk("R6 still locked", int'(lock_active), 1);
        lock_s = 1'b1;
        tick();
        chk("R6 lock end", int'(lock_end), 1);
        chk("R6 clean lock errors", int'(err_flags), 0);
        tick();

        // Error injections, one at a time.
        rdy_s = 1'b0;
        tick();
        rdy_s = 1'b1;
        chk("R12 stray ready", int'(err_flags[4]), 1);
        tick();

        ads_s = 1'b0; code_s = 3'b110; lock_s = 1'b1;
        tick();
        tick();
        ads_s = 1'b1;
        chk("R9 overlap", int'(err_flags[1]), 1);
        rdy_s = 1'b0;
        tick();
        rdy_s = 1'b1;
        tick();

        ads_s = 1'b0; code_s = 3'b110; lock_s = 1'b0;
        tick();
        ads_s = 1'b1; brdy_s = 1'b0; last_s = 1'b1;
        tick();
        chk("R11 locked burst", int'(err_flags[3]), 1);
        last_s = 1'b0;
        tick();
        brdy_s = 1'b1; last_s = 1'b1;
        hold_s = 1'b1;
        tick();
        hold_s = 1'b0;
        chk("R10 hold under lock", int'(err_flags[2]), 1);
        lock_s = 1'b1;
        tick();

        ads_s = 1'b0; code_s = 3'b010; lock_s = 1'b0;
        tick();
        ads_s = 1'b1; lock_s = 1'b1;
        tick();
        chk("R13 early release", int'(err_flags[5]), 1);
        rdy_s = 1'b0;
        tick();
        rdy_s = 1'b1;
        tick();

        run_cycle(3'b101, 4'b0000, 3'b000, 1'b1, 1, 1'b1);
        chk("R8 reserved code", int'(err_flags[0]), 1);
        chk("R1 reserved type", int'(cyc_type), 5);
        tick(); tick();
        chk("R14 all sticky", int'(err_flags), 63);

        // Reset clears everything (R14, R3).
        rst_n = 1'b0;
        tick(); tick();
        chk("R14 cleared by reset", int'(err_flags), 0);
        chk("R3 type after reset", int'(cyc_type), 15);
        rst_n = 1'b1;
        tick();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule